// File: doc/BRIEF.md
# PCI Interrupt Router and CPU Trigger Stage

This block takes interrupt events from devices on a PCI segment and turns each one into an internal interrupt number of the bridge. Each event gives the device's slot number and the interrupt pin it uses (0 to 3 for A to D). Devices on the fixed on-board slots get set numbers. Expansion slots rotate their pins across a shared group of lines. Any other slot passes its pin index through unchanged.

The mapped number, less the interrupt base of 32, selects one bit in each of two configuration words. One word chooses edge or level behaviour for each line, and the other gives the level. An edge line produces a single-cycle pulse on the CPU interrupt output. A level line drives the output to its polarity bit and holds it there until the next event. The mapped number of the latest event stays on its own output, so the rest of the bridge can see which line fired.

Top module: `irq_route_unit`

## Requirements
- R1: After synchronous reset, `irq_num` is 0 and `cpu_irq` is 0.
- R2: An event from slot 5 maps to 32 + pin.
- R3: An event from slot 6 maps to 36 and one from slot 7 maps to 37, whatever the pin.
- R4: An event from slots 8 through 12 maps to (slot - 8 + pin) + 38, which lies in 38..45.
- R5: An event from any other slot maps to the pin index itself (0..3).
- R6: `irq_num` takes the mapped value on the clock edge at which `evt_valid` is high. It holds while `evt_valid` is low, and so does `cpu_irq` once any pulse is over.
- R7: When the mapped number is in 32..63 and bit (number - 32) of `edge_cfg` is 1, `cpu_irq` is 1 for exactly the one cycle after the event and then returns to 0.
- R8: When the mapped number is in 32..63 and that `edge_cfg` bit is 0, `cpu_irq` becomes bit (number - 32) of `pol_cfg` and keeps that value until the next event.
- R9: An event whose mapped number is outside 32..63 leaves the level of `cpu_irq` unchanged. A pulse that is already in progress still ends on schedule.
- R10: When both the edge bit and the polarity bit of a line are set, edge behaviour wins and only a single-cycle pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | A device interrupt event is present this cycle |
| evt_slot | input | 5 | Slot number of the signalling device |
| evt_pin | input | 2 | Interrupt pin index, 0 = A through 3 = D |
| edge_cfg | input | 32 | Per-line trigger select, bit n for line 32+n: 1 = edge, 0 = level |
| pol_cfg | input | 32 | Per-line level value, bit n for line 32+n |
| irq_num | output | 8 | Mapped interrupt number of the latest event |
| cpu_irq | output | 1 | Interrupt output to the CPU |

## Verification
The assertions check several rules on every cycle. A pulse that gets no fresh event ends after one cycle. A level event copies its polarity bit to the output. The output and the mapped number hold when nothing happens. Expansion-slot events always land in 38..45. The exact number for each slot class, the priority of edge over polarity, and the untouched output after an out-of-range event only show up in the bench's scenarios. Those scenarios compare the ports against a reference model in the bench, using both directed and seeded random events with random configuration words.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int IRQ_BASE     = 32;
    localparam int SLOT_MULTI   = 5;
    localparam int SLOT_VIDEO   = 6;
    localparam int SLOT_NET     = 7;
    localparam int EXP_FIRST    = 8;
    localparam int EXP_LAST     = 12;
    localparam int EXP_LINE_OFS = 6;
    localparam int VIDEO_LINE   = 4;
    localparam int NET_LINE     = 5;

    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2
    } trig_e;

    typedef struct packed {
        trig_e mode;
        logic  level;
    } trig_req_t;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
    import irq_route_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int PIN_W  = 2,
    parameter int NUM_W  = 8
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output logic [NUM_W-1:0]  num
);
    localparam logic [NUM_W-1:0] BASE_N  = NUM_W'(IRQ_BASE);
    localparam logic [NUM_W-1:0] EXP_ADD = NUM_W'(IRQ_BASE + EXP_LINE_OFS);

    logic [NUM_W-1:0] slot_n;
    logic [NUM_W-1:0] pin_n;

    assign slot_n = NUM_W'(slot);
    assign pin_n  = NUM_W'(pin);

    always_comb begin
        if (slot_n == NUM_W'(SLOT_MULTI)) begin
            num = BASE_N + NUM_W'(pin % 4);
        end else if (slot_n == NUM_W'(SLOT_VIDEO)) begin
            num = BASE_N + NUM_W'(VIDEO_LINE);
        end else if (slot_n == NUM_W'(SLOT_NET)) begin
            num = BASE_N + NUM_W'(NET_LINE);
        end else if (slot_n >= NUM_W'(EXP_FIRST) && slot_n <= NUM_W'(EXP_LAST)) begin
            num = slot_n - NUM_W'(EXP_FIRST) + pin_n + EXP_ADD;
        end else begin
            num = pin_n;
        end
    end
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_route_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [NUM_W-1:0] num,
    input  logic [CFG_W-1:0] edge_cfg,
    input  logic [CFG_W-1:0] pol_cfg,
    output logic             irq
);
    localparam int IDX_W = $clog2(CFG_W);

    logic [NUM_W-1:0] rel;
    logic             in_range;
    logic [IDX_W-1:0] idx;
    trig_req_t        req;
    logic             irq_q;
    logic             pulse_q;

    assign rel      = num - NUM_W'(IRQ_BASE);
    assign in_range = (num >= NUM_W'(IRQ_BASE)) && (rel < NUM_W'(CFG_W));
    assign idx      = rel[IDX_W-1:0];

    always_comb begin
        req.level = pol_cfg[idx];
        if (!(valid && in_range)) begin
            req.mode = TRIG_NONE;
        end else if (edge_cfg[idx]) begin
            req.mode = TRIG_EDGE;
        end else begin
            req.mode = TRIG_LEVEL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            case (req.mode)
                TRIG_EDGE: begin
                    irq_q   <= 1'b1;
                    pulse_q <= 1'b1;
                end
                TRIG_LEVEL: begin
                    irq_q   <= req.level;
                    pulse_q <= 1'b0;
                end
                default: begin
                    if (pulse_q) begin
                        irq_q   <= 1'b0;
                        pulse_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign irq = irq_q;

    assert_pulse_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && req.mode == TRIG_NONE) |=> !irq_q);

    assert_edge_raises_R10: assert property (@(posedge clk) disable iff (rst)
        (req.mode == TRIG_EDGE) |=> irq_q);

    assert_level_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && in_range && !edge_cfg[idx]) |=> (irq_q == $past(pol_cfg[idx])));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!(valid && in_range) && !pulse_q) |=> $stable(irq_q));
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int PIN_W  = 2,
    parameter int NUM_W  = 8,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic [PIN_W-1:0]  evt_pin,
    input  logic [CFG_W-1:0]  edge_cfg,
    input  logic [CFG_W-1:0]  pol_cfg,
    output logic [NUM_W-1:0]  irq_num,
    output logic              cpu_irq
);
    logic [NUM_W-1:0] mapped;
    logic [NUM_W-1:0] num_q;

    irq_slot_map #(.SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W)) u_map (
        .slot (evt_slot),
        .pin  (evt_pin),
        .num  (mapped)
    );

    irq_trigger #(.NUM_W(NUM_W), .CFG_W(CFG_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .valid    (evt_valid),
        .num      (mapped),
        .edge_cfg (edge_cfg),
        .pol_cfg  (pol_cfg),
        .irq      (cpu_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= '0;
        end else if (evt_valid) begin
            num_q <= mapped;
        end
    end

    assign irq_num = num_q;

    assert_num_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> $stable(irq_num));

    assert_exp_range_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_slot >= SLOT_W'(EXP_FIRST) && evt_slot <= SLOT_W'(EXP_LAST))
        |=> (irq_num >= NUM_W'(IRQ_BASE + EXP_LINE_OFS) && irq_num <= NUM_W'(IRQ_BASE + EXP_LINE_OFS + 7)));
endmodule

// File: tb/sim_irq_route_unit.sv
module sim_irq_route_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [4:0]  evt_slot;
    logic [1:0]  evt_pin;
    logic [31:0] edge_cfg;
    logic [31:0] pol_cfg;
    logic [7:0]  irq_num;
    logic        cpu_irq;

    int n_chk  = 0;
    int n_fail = 0;

    int  exp_num   = 0;
    logic exp_irq   = 1'b0;
    logic exp_pulse = 1'b0;

    always #10 clk = ~clk;

    irq_route_unit u0 (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_slot(evt_slot),
        .evt_pin(evt_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
        .irq_num(irq_num), .cpu_irq(cpu_irq)
    );

    function automatic int ref_map(int s, int p);
        if (s == 5) return 32 + (p % 4);
        if (s == 6) return 36;
        if (s == 7) return 37;
        if (s >= 8 && s <= 12) return (s - 8 + p) + 6 + 32;
        return p;
    endfunction

    function automatic string map_tag(int s);
        if (s == 5) return "R2";
        if (s == 6 || s == 7) return "R3";
        if (s >= 8 && s <= 12) return "R4";
        return "R5";
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle, update the reference model, check after the edge
    task automatic step(bit v, int s, int p, logic [31:0] e, logic [31:0] pl);
        string ntag;
        string itag;
        int    m;
        @(negedge clk);
        evt_valid = v; evt_slot = 5'(s); evt_pin = 2'(p);
        edge_cfg = e; pol_cfg = pl;
        ntag = "R6"; itag = exp_pulse ? "R7" : "R6";
        if (v) begin
            m = ref_map(s, p);
            exp_num = m;
            ntag = map_tag(s);
            if (m >= 32 && m <= 63) begin
                if (e[m-32]) begin
                    exp_irq = 1'b1; exp_pulse = 1'b1;
                    itag = pl[m-32] ? "R10" : "R7";
                end else begin
                    exp_irq = pl[m-32]; exp_pulse = 1'b0; itag = "R8";
                end
            end else begin
                itag = "R9";
                if (exp_pulse) begin exp_irq = 1'b0; exp_pulse = 1'b0; end
            end
        end else if (exp_pulse) begin
            exp_irq = 1'b0; exp_pulse = 1'b0;
        end
        @(negedge clk);
        chk(ntag, int'(irq_num), exp_num);
        chk(itag, int'(cpu_irq), int'(exp_irq));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; evt_valid = 1'b0; evt_slot = '0; evt_pin = '0;
        edge_cfg = '0; pol_cfg = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(irq_num), 0);
        chk("R1", int'(cpu_irq), 0);
        rst = 1'b0;

        // R2 slot 5, pin 3 -> 35, level high
        step(1, 5, 3, 32'h0, 32'h8);
        // R6/R8 level held while idle
        step(0, 0, 0, 32'h0, 32'h0);
        step(0, 0, 0, 32'hFFFF_FFFF, 32'h0);
        // R3 slot 6 any pin -> 36, level low
        step(1, 6, 2, 32'h0, 32'h0);
        // R3 slot 7 -> 37, edge pulse then end
        step(1, 7, 1, 32'h20, 32'h0);
        step(0, 0, 0, 32'h0, 32'h0);
        // R4 bounds: slot 8 pin 0 -> 38, slot 12 pin 3 -> 45
        step(1, 8, 0, 32'h0, 32'h40);
        step(1, 12, 3, 32'h0, 32'h0);
        // R5/R9 other slot passes pin, output level untouched
        step(1, 5, 0, 32'h0, 32'h1);
        step(1, 3, 2, 32'hFFFF_FFFF, 32'h0);
        step(1, 20, 1, 32'h0, 32'h0);
        // R10 edge wins over polarity
        step(1, 10, 1, 32'h200, 32'h200);
        step(0, 0, 0, 32'h200, 32'h200);
        // R9 out-of-range during pulse: pulse still ends
        step(1, 9, 0, 32'h80, 32'h0);
        step(1, 1, 3, 32'h0, 32'h0);

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 4),
                 $urandom, $urandom);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule